// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block watches a microcontroller through an active-low trigger line and pulls an active-low reset line when the controller misbehaves. It runs on the system clock. A separate one-cycle tick enable sets the timebase, and every duration is counted in ticks.

When power-good is released, the block first holds reset for a power-up interval. It then allows a long lead interval, during which the first trigger must arrive. After that it cycles through two windows:

- A closed window, in which a trigger counts as a fault and resets the controller at once.
- An open window, in which a trigger is required. A trigger there starts a new closed window, and silence causes a reset.

Each watchdog reset pulse is followed by a fresh lead interval.

Before it counts, a trigger passes a two-flop synchroniser and a minimum-width filter. A low-power input switches supervision off. Supervision resumes only on a falling edge of a wake input, and that edge starts a new lead interval. A status output shows the current phase. A sticky cause output records why the last watchdog reset happened.

Top module: `wdw_window`

## Requirements
- R1: While `rst_n` is low, `res_n`=0, `phase`=0 (RESET) and `cause`=0. After release, `res_n` stays low for POR_TICKS ticks, and then `phase` becomes 1 (LEAD).
- R2: A trigger event is produced only after the synchronised `trig_n` has been low for FILT_CLKS consecutive clocks. Shorter low pulses have no effect. A low level held for any length gives exactly one event.
- R3: LEAD lasts LEAD_TICKS ticks. If it ends without a trigger, the block enters RESET (`res_n`=0) and sets `cause`=2 (missing trigger).
- R4: A trigger event during LEAD moves the block to `phase`=2 (CLOSED) on the next clock.
- R5: A trigger event during CLOSED moves the block to RESET on the next clock and sets `cause`=1 (early trigger).
- R6: CLOSED lasts CLOSED_TICKS ticks and is followed by `phase`=3 (OPEN).
- R7: A trigger event during OPEN starts a new CLOSED window on the next clock.
- R8: If OPEN runs OPEN_TICKS ticks without a trigger, the block enters RESET with `cause`=2.
- R9: A watchdog reset pulse lasts PULSE_TICKS ticks, after which the block returns to LEAD.
- R10: While `sleep` is high, `phase`=4 (OFF), `res_n`=1 and triggers are ignored. After `sleep` falls, the block stays in OFF until the synchronised `wake_n` shows a falling edge, and then it enters LEAD.
- R11: Trigger events during RESET are ignored, and the pulse still ends in LEAD.
- R12: `cause` changes only when a watchdog reset begins and keeps its value otherwise. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-good; asynchronous clear |
| tick | input | 1 | One-cycle timebase enable |
| trig_n | input | 1 | Active-low trigger from the supervised controller |
| sleep | input | 1 | High switches supervision off |
| wake_n | input | 1 | Falling edge restarts supervision after sleep |
| res_n | output | 1 | Active-low reset to the controller |
| phase | output | 3 | 0 RESET, 1 LEAD, 2 CLOSED, 3 OPEN, 4 OFF |
| cause | output | 2 | 0 none, 1 early trigger, 2 missing trigger |

## Verification
The assertions assume that `sleep` and `tick` are synchronous to `clk` and change only between edges. They also assume that `rst_n` is held low for several clocks at start-up, so every register begins from a known value. The stimulus drives all inputs on the falling clock edge and generates the tick as a regular one-in-two enable. Trigger and wake pulses are produced by tasks with explicit low lengths, so each case lands plainly above or below the filter width.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [2:0] {
    PH_RESET  = 3'd0,
    PH_LEAD   = 3'd1,
    PH_CLOSED = 3'd2,
    PH_OPEN   = 3'd3,
    PH_OFF    = 3'd4
  } wdw_phase_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_EARLY   = 2'd1,
    CAUSE_MISSING = 2'd2
  } wdw_cause_e;

  // Largest of the phase lengths, used to size the shared down counter.
  function automatic int unsigned longest(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d,
                                          input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/wdw_sync.sv
module wdw_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdw_trig_filter.sv
module wdw_trig_filter #(
  parameter int unsigned FILT_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_s,
  output logic trig_evt
);
  localparam int unsigned RW = $clog2(FILT_CLKS + 1);

  logic [RW-1:0] run;
  logic          fired;
  logic          width_met;

  assign width_met = (run == RW'(FILT_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      fired    <= 1'b0;
      trig_evt <= 1'b0;
    end else begin
      trig_evt <= 1'b0;
      if (trig_s) begin
        run   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (width_met) begin
          trig_evt <= 1'b1;
          fired    <= 1'b1;
        end else begin
          run <= run + RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdw_phase_fsm.sv
module wdw_phase_fsm
  import wdw_pkg::*;
#(
  parameter int unsigned LEAD_TICKS   = 7895,
  parameter int unsigned CLOSED_TICKS = 1053,
  parameter int unsigned OPEN_TICKS   = 1105,
  parameter int unsigned PULSE_TICKS  = 204,
  parameter int unsigned POR_TICKS    = 204
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sleep,
  input  logic       trig_evt,
  input  logic       wake_fall,
  output wdw_phase_e phase,
  output wdw_cause_e cause,
  output logic       expire
);
  localparam int unsigned MAXL = longest(LEAD_TICKS, CLOSED_TICKS, OPEN_TICKS,
                                         PULSE_TICKS, POR_TICKS);
  localparam int unsigned CW   = $clog2(MAXL + 1);

  function automatic logic [CW-1:0] span(input int unsigned n);
    return CW'(n - 1);
  endfunction

  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RESET;
      cnt   <= span(POR_TICKS);
      cause <= CAUSE_NONE;
    end else if (sleep) begin
      phase <= PH_OFF;
      cnt   <= span(LEAD_TICKS);
    end else begin
      unique case (phase)
        PH_OFF: begin
          if (wake_fall) begin
            phase <= PH_LEAD;
            cnt   <= span(LEAD_TICKS);
          end
        end
        PH_RESET: begin
          if (expire) begin
            phase <= PH_LEAD;
            cnt   <= span(LEAD_TICKS);
          end else if (tick) begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_LEAD, PH_OPEN: begin
          if (trig_evt) begin
            phase <= PH_CLOSED;
            cnt   <= span(CLOSED_TICKS);
          end else if (expire) begin
            phase <= PH_RESET;
            cnt   <= span(PULSE_TICKS);
            cause <= CAUSE_MISSING;
          end else if (tick) begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_CLOSED: begin
          if (trig_evt) begin
            phase <= PH_RESET;
            cnt   <= span(PULSE_TICKS);
            cause <= CAUSE_EARLY;
          end else if (expire) begin
            phase <= PH_OPEN;
            cnt   <= span(OPEN_TICKS);
          end else if (tick) begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          phase <= PH_RESET;
          cnt   <= span(PULSE_TICKS);
        end
      endcase
    end
  end
endmodule

// File: rtl/wdw_window.sv
module wdw_window
  import wdw_pkg::*;
#(
  parameter int unsigned LEAD_TICKS   = 7895,
  parameter int unsigned CLOSED_TICKS = 1053,
  parameter int unsigned OPEN_TICKS   = 1105,
  parameter int unsigned PULSE_TICKS  = 204,
  parameter int unsigned POR_TICKS    = 204,
  parameter int unsigned FILT_CLKS    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       trig_n,
  input  logic       sleep,
  input  logic       wake_n,
  output logic       res_n,
  output logic [2:0] phase,
  output logic [1:0] cause
);
  logic       trig_s;
  logic       trig_evt;
  logic       wake_s;
  logic       wake_d;
  logic       wake_fall;
  logic       expire;
  wdw_phase_e ph;
  wdw_cause_e cs;

  wdw_sync #(.RST_VAL(1'b1)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_n), .q(trig_s)
  );

  wdw_sync #(.RST_VAL(1'b1)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_n), .q(wake_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_d <= 1'b1;
    else        wake_d <= wake_s;
  end

  assign wake_fall = wake_d && !wake_s;

  wdw_trig_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .trig_s(trig_s), .trig_evt(trig_evt)
  );

  wdw_phase_fsm #(
    .LEAD_TICKS(LEAD_TICKS), .CLOSED_TICKS(CLOSED_TICKS), .OPEN_TICKS(OPEN_TICKS),
    .PULSE_TICKS(PULSE_TICKS), .POR_TICKS(POR_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep(sleep), .trig_evt(trig_evt),
    .wake_fall(wake_fall), .phase(ph), .cause(cs), .expire(expire)
  );

  assign phase = ph;
  assign cause = cs;
  assign res_n = (ph != PH_RESET);
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
  import wdw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       trig_evt,
  input logic [2:0] phase,
  input logic [1:0] cause,
  input logic       res_n
);
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt);

  a_r4_lead_to_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD && trig_evt && !sleep) |=> phase == PH_CLOSED);

  a_r5_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOSED && trig_evt && !sleep) |=> (phase == PH_RESET && cause == CAUSE_EARLY && !res_n));

  a_r7_open_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPEN && trig_evt && !sleep) |=> phase == PH_CLOSED);

  a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (phase == PH_OFF && res_n));

  a_r11_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESET && !sleep) |=> (phase == PH_RESET || phase == PH_LEAD));

  a_r12_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause) |-> phase == PH_RESET);
endmodule

bind wdw_window wdw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .trig_evt(trig_evt),
  .phase(phase), .cause(cause), .res_n(res_n)
);

// File: tb/sim_wdw_window.sv
module sim_wdw_window;
  localparam int LEAD = 40, CLS = 10, OPN = 12, PUL = 6, POR = 5, FILT = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, trig_n = 1'b1, sleep = 1'b0, wake_n = 1'b1;
  logic       res_n;
  logic [2:0] phase;
  logic [1:0] cause;

  int total = 0, bad = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdw_window #(
    .LEAD_TICKS(LEAD), .CLOSED_TICKS(CLS), .OPEN_TICKS(OPN),
    .PULSE_TICKS(PUL), .POR_TICKS(POR), .FILT_CLKS(FILT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_n(trig_n), .sleep(sleep),
    .wake_n(wake_n), .res_n(res_n), .phase(phase), .cause(cause)
  );

  // timebase: one tick every second clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick = (tdiv == 0);
  end

  // behavioural reference
  int    m_ph = 0, m_left = POR, m_cause = 0;
  bit    m_evt = 0;
  bit    th[FILT+2];
  bit    wh[3];
  string m_tag = "R1";

  task automatic go(input int p, input int n, input string t);
    m_ph = p; m_left = n; m_tag = t;
  endtask

  always @(posedge clk) begin : model
    bit evt_now, wf, ok;
    if (!rst_n) begin
      m_ph = 0; m_left = POR; m_cause = 0; m_evt = 0; m_tag = "R1";
      foreach (th[j]) th[j] = 1'b1;
      foreach (wh[j]) wh[j] = 1'b1;
    end else begin
      wf = (wh[1] == 1'b0) && (wh[2] == 1'b1);
      if (sleep) go(4, LEAD, "R10");
      else begin
        case (m_ph)
          4: if (wf) go(1, LEAD, "R10");
          0: if (tick) begin
               if (m_left == 1) go(1, LEAD, "R9"); else m_left--;
             end
          1, 3: if (m_evt) go(2, CLS, m_ph == 1 ? "R4" : "R7");
                else if (tick) begin
                  if (m_left == 1) begin
                    m_cause = 2; go(0, PUL, m_ph == 1 ? "R3" : "R8");
                  end else m_left--;
                end
          2: if (m_evt) begin m_cause = 1; go(0, PUL, "R5"); end
             else if (tick) begin
               if (m_left == 1) go(3, OPN, "R6"); else m_left--;
             end
          default: ;
        endcase
      end
      ok = 1'b1;
      for (int j = 1; j <= FILT; j++) if (th[j] != 1'b0) ok = 1'b0;
      evt_now = ok && (th[FILT+1] == 1'b1);
      m_evt = evt_now;
      for (int j = FILT + 1; j >= 1; j--) th[j] = th[j-1];
      th[0] = trig_n;
      for (int j = 2; j >= 1; j--) wh[j] = wh[j-1];
      wh[0] = wake_n;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(m_tag, "phase", int'(phase), m_ph);
      chk(m_tag, "res_n", int'(res_n), (m_ph != 0) ? 1 : 0);
      chk("R12", "cause", int'(cause), m_cause);
    end
  end

  task automatic wait_ph(input int p, input string tag);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (int'(phase) == p) return;
    end
    chk(tag, "wait phase", int'(phase), p);
  endtask

  task automatic pulse_trig(input int len);
    @(negedge clk); trig_n = 1'b0;
    repeat (len) @(negedge clk);
    trig_n = 1'b1;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "reset phase", int'(phase), 0);
    chk("R1", "reset res_n", int'(res_n), 0);
    chk("R1", "reset cause", int'(cause), 0);
    rst_n = 1'b1;
    @(negedge clk); cmp_en = 1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    wait_ph(1, "R1");
    chk("R1", "lead after power-up", int'(phase), 1);
    wait_ph(0, "R3");
    chk("R3", "missing-trigger cause", int'(cause), 2);
    wait_ph(1, "R9");
    // lead -> closed
    pulse_trig(FILT + 2);
    wait_ph(2, "R4");
    // glitch shorter than the filter
    pulse_trig(FILT - 2);
    repeat (10) @(negedge clk);
    chk("R2", "glitch ignored", int'(phase), 2);
    wait_ph(3, "R6");
    pulse_trig(FILT + 2);
    wait_ph(2, "R7");
    wait_ph(3, "R6");
    // long low level: one event only
    @(negedge clk); trig_n = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2", "single event on held low", int'(phase), 3);
    trig_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse_trig(FILT + 2);
    wait_ph(2, "R7");
    repeat (2) @(negedge clk);
    pulse_trig(FILT + 2);
    wait_ph(0, "R5");
    chk("R5", "early cause", int'(cause), 1);
    // trigger during reset pulse
    pulse_trig(FILT + 1);
    wait_ph(1, "R11");
    repeat (4) @(negedge clk);
    chk("R11", "reset ignores trigger", int'(phase), 1);
    chk("R12", "cause held", int'(cause), 1);
    // open window expiry
    pulse_trig(FILT + 2);
    wait_ph(2, "R4");
    wait_ph(3, "R6");
    wait_ph(0, "R8");
    chk("R8", "open expiry cause", int'(cause), 2);
    // sleep and wake
    wait_ph(1, "R9");
    @(negedge clk); sleep = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "off phase", int'(phase), 4);
    chk("R10", "off res_n", int'(res_n), 1);
    pulse_trig(FILT + 2);
    repeat (5) @(negedge clk);
    chk("R10", "trigger ignored when off", int'(phase), 4);
    sleep = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10", "waits for wake edge", int'(phase), 4);
    wake_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10", "wake starts lead", int'(phase), 1);
    wake_n = 1'b1;
    repeat (10) @(negedge clk);
    // power-good clears cause
    do_reset();
    chk("R12", "cause cleared", int'(cause), 0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule